// File: doc/BRIEF.md
# Shared-Bus Wishbone Interconnect

This block joins one Wishbone master to a set of up to sixteen slaves over a shared bus. The master address is split in two. The upper four bits name a slave slot. The low eight bits are the register address inside that slave. The register address, the write data and the write-enable level go to every slave. Only the slot that is both addressed and populated gets its cycle, strobe and write-enable lines raised. The acknowledge and read data from that one slave are multiplexed back to the master.

There is a single master, so there is no arbiter. There are no byte-select lines. Which slots hold a slave is fixed at build time by a bitmask parameter. An access to an empty slot goes to a built-in responder. It acknowledges after a fixed number of strobe cycles and returns zero, so a stray address cannot stall the bus. Everything runs on one clock, and a synchronous reset drops any response that the responder has half counted.

Top module: `wb_shared_bus`

## Requirements
- R1: While reset is high and the master is idle, no slave sees cycle or strobe and the master acknowledge is low.
- R2: The slot number is m_adr[11:8]. During a master cycle, s_cyc carries exactly the bit of that slot if the slot is populated (SLOT_MAP bit set), and is zero otherwise. s_stb follows the same rule when m_stb is also high.
- R3: s_adr always equals m_adr[7:0], and s_dat_w always equals m_dat_w, for all slots.
- R4: s_we is set only for the addressed populated slot, only during a cycle, and only while m_we is high.
- R5: For a populated slot, m_ack is that slave's s_ack bit, gated by m_cyc and m_stb. Acknowledges raised by any other slot are ignored.
- R6: For a populated slot, m_dat_r is that slave's 16-bit slice of s_dat_r. Slot k occupies bits [16k+15:16k].
- R7: For an empty slot, no slave line is raised and m_dat_r is 0x0000. m_ack rises in the UNMAP_LAT-th consecutive strobe cycle (default 3), whatever the s_ack inputs are.
- R8: When m_cyc and m_stb are not both high, every s_stb bit is low and m_ack is low, even if slaves drive acknowledge.
- R9: A synchronous reset during a pending access to an empty slot restarts its count. The acknowledge then comes UNMAP_LAT strobe cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| m_cyc | input | 1 | Master bus cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_adr | input | 12 | Slot number [11:8], register address [7:0] |
| m_dat_w | input | 16 | Master write data |
| m_dat_r | output | 16 | Read data to master |
| m_ack | output | 1 | Acknowledge to master |
| s_cyc | output | 16 | Per-slot cycle |
| s_stb | output | 16 | Per-slot strobe |
| s_we | output | 16 | Per-slot write enable |
| s_adr | output | 8 | Shared register address |
| s_dat_w | output | 16 | Shared write data |
| s_dat_r | input | 256 | Per-slot read data, 16 bits per slot |
| s_ack | input | 16 | Per-slot acknowledge |

## Verification
Slave models in the bench each use a different wait-state count (slot number modulo 3). The measured handshake length therefore shows whether the acknowledge came from the addressed slave or from the empty-slot responder. Random reads and writes over all sixteen slots are mixed with spurious acknowledges on the slots that are not addressed. These separate correct return-path selection from a design that ORs or mis-indexes the acknowledges. Directed cases cover:
- Register addresses 0x00 and 0xFF in every slot.
- A cycle held with the strobe low.
- A reset issued in the middle of an empty-slot access.

Read-back against a shadow memory separates write routing faults from read-mux faults.

// File: rtl/wbsb_pkg.sv
package wbsb_pkg;

    // counter used by the empty-slot responder; bounds UNMAP_LAT to 256
    typedef logic [7:0] wait_cnt_t;

    typedef struct packed {
        wait_cnt_t cnt;
    } null_state_t;

endpackage

// File: rtl/wbsb_decode.sv
module wbsb_decode #(
    parameter int                     SEL_W    = 4,
    parameter logic [(1<<SEL_W)-1:0]  SLOT_MAP = '1
) (
    input  logic [SEL_W-1:0]          slot,
    output logic [(1<<SEL_W)-1:0]     hit,
    output logic                      mapped
);
    localparam int N_SLOTS = 1 << SEL_W;

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_hit
        if (SLOT_MAP[k]) begin : g_pop
            assign hit[k] = (slot == SEL_W'(k));
        end else begin : g_empty
            assign hit[k] = 1'b0;
        end
    end

    assign mapped = |hit;
endmodule

// File: rtl/wbsb_ret_mux.sv
module wbsb_ret_mux #(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]                  slot,
    input  logic                              mapped,
    input  logic                              req,
    input  logic                              null_ack,
    input  logic [(1<<SEL_W)-1:0]             s_ack,
    input  logic [(1<<SEL_W)*DATA_W-1:0]      s_dat_r,
    output logic                              m_ack,
    output logic [DATA_W-1:0]                 m_dat_r
);
    localparam int N_SLOTS = 1 << SEL_W;

    logic [DATA_W-1:0] dat_arr [N_SLOTS];

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_split
        assign dat_arr[k] = s_dat_r[k*DATA_W +: DATA_W];
    end

    always_comb begin
        if (mapped) begin
            m_ack   = req & s_ack[slot];
            m_dat_r = dat_arr[slot];
        end else begin
            m_ack   = req & null_ack;
            m_dat_r = '0;
        end
    end
endmodule

// File: rtl/wbsb_null_resp.sv
module wbsb_null_resp
    import wbsb_pkg::*;
#(
    parameter int UNMAP_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic ack
);
    localparam wait_cnt_t LAST = wait_cnt_t'(UNMAP_LAT - 1);

    null_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ack  = req && (st_q.cnt == LAST);
        if (!req || ack) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wb_shared_bus.sv
module wb_shared_bus #(
    parameter int                     DATA_W    = 16,
    parameter int                     REG_AW    = 8,
    parameter int                     SEL_W     = 4,
    parameter logic [(1<<SEL_W)-1:0]  SLOT_MAP  = 16'h0C3F,
    parameter int                     UNMAP_LAT = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              m_cyc,
    input  logic                              m_stb,
    input  logic                              m_we,
    input  logic [SEL_W+REG_AW-1:0]           m_adr,
    input  logic [DATA_W-1:0]                 m_dat_w,
    output logic [DATA_W-1:0]                 m_dat_r,
    output logic                              m_ack,
    output logic [(1<<SEL_W)-1:0]             s_cyc,
    output logic [(1<<SEL_W)-1:0]             s_stb,
    output logic [(1<<SEL_W)-1:0]             s_we,
    output logic [REG_AW-1:0]                 s_adr,
    output logic [DATA_W-1:0]                 s_dat_w,
    input  logic [(1<<SEL_W)*DATA_W-1:0]      s_dat_r,
    input  logic [(1<<SEL_W)-1:0]             s_ack
);
    localparam int N_SLOTS = 1 << SEL_W;
    localparam int ADR_W   = SEL_W + REG_AW;

    logic [SEL_W-1:0]   slot;
    logic [N_SLOTS-1:0] hit;
    logic               mapped;
    logic               req;
    logic               null_ack;

    assign slot = m_adr[ADR_W-1:REG_AW];
    assign req  = m_cyc & m_stb;

    wbsb_decode #(
        .SEL_W    (SEL_W),
        .SLOT_MAP (SLOT_MAP)
    ) u_dec (
        .slot   (slot),
        .hit    (hit),
        .mapped (mapped)
    );

    // shared forward path, gated select lines
    assign s_adr   = m_adr[REG_AW-1:0];
    assign s_dat_w = m_dat_w;
    assign s_cyc   = m_cyc ? hit : '0;
    assign s_stb   = req   ? hit : '0;
    assign s_we    = (m_cyc && m_we) ? hit : '0;

    wbsb_null_resp #(
        .UNMAP_LAT (UNMAP_LAT)
    ) u_null (
        .clk (clk),
        .rst (rst),
        .req (req & ~mapped),
        .ack (null_ack)
    );

    wbsb_ret_mux #(
        .SEL_W  (SEL_W),
        .DATA_W (DATA_W)
    ) u_ret (
        .slot     (slot),
        .mapped   (mapped),
        .req      (req),
        .null_ack (null_ack),
        .s_ack    (s_ack),
        .s_dat_r  (s_dat_r),
        .m_ack    (m_ack),
        .m_dat_r  (m_dat_r)
    );
endmodule

// File: rtl/wb_shared_bus_chk.sv
module wb_shared_bus_chk #(
    parameter int                     DATA_W    = 16,
    parameter int                     SEL_W     = 4,
    parameter logic [(1<<SEL_W)-1:0]  SLOT_MAP  = 16'h0C3F,
    parameter int                     UNMAP_LAT = 3
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   m_cyc,
    input logic                   m_stb,
    input logic                   m_we,
    input logic [SEL_W-1:0]       slot,
    input logic                   m_ack,
    input logic [DATA_W-1:0]      m_dat_r,
    input logic [(1<<SEL_W)-1:0]  s_cyc,
    input logic [(1<<SEL_W)-1:0]  s_stb,
    input logic [(1<<SEL_W)-1:0]  s_we,
    input logic [(1<<SEL_W)-1:0]  s_ack
);
    localparam int         N_SLOTS = 1 << SEL_W;
    localparam logic [7:0] LAST    = 8'(UNMAP_LAT - 1);

    logic       req;
    logic       empty;
    logic [7:0] held;

    assign req   = m_cyc && m_stb;
    assign empty = !SLOT_MAP[slot];

    // consecutive unacknowledged strobe cycles seen at the master port
    always_ff @(posedge clk) begin
        if (rst)                held <= '0;
        else if (req && !m_ack) held <= held + 8'd1;
        else                    held <= '0;
    end

    a_r2_stb_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_stb));

    a_r2_stb_target: assert property (@(posedge clk) disable iff (rst)
        (|s_stb) |-> (s_stb == (N_SLOTS'(1) << slot)));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req |-> (s_stb == '0 && !m_ack));

    a_r4_we_needs_master_we: assert property (@(posedge clk) disable iff (rst)
        (|s_we) |-> (m_we && m_cyc));

    a_r5_ack_from_target: assert property (@(posedge clk) disable iff (rst)
        (m_ack && !empty) |-> s_ack[slot]);

    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        (m_cyc && empty) |-> (s_cyc == '0 && m_dat_r == '0));

    a_r7_empty_ack_due: assert property (@(posedge clk) disable iff (rst)
        (req && empty && held == LAST) |-> m_ack);

    a_r7_empty_ack_early: assert property (@(posedge clk) disable iff (rst)
        (req && empty && held != LAST) |-> !m_ack);
endmodule

bind wb_shared_bus wb_shared_bus_chk #(
    .DATA_W    (DATA_W),
    .SEL_W     (SEL_W),
    .SLOT_MAP  (SLOT_MAP),
    .UNMAP_LAT (UNMAP_LAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .m_cyc   (m_cyc),
    .m_stb   (m_stb),
    .m_we    (m_we),
    .slot    (m_adr[SEL_W+REG_AW-1:REG_AW]),
    .m_ack   (m_ack),
    .m_dat_r (m_dat_r),
    .s_cyc   (s_cyc),
    .s_stb   (s_stb),
    .s_we    (s_we),
    .s_ack   (s_ack)
);

// File: tb/sim_wb_shared_bus.sv
module sim_wb_shared_bus;
    localparam int          CLK_NS    = 10;
    localparam logic [15:0] SLOT_MAP  = 16'h0C3F;
    localparam int          UNMAP_LAT = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          m_cyc, m_stb, m_we;
    logic [11:0]   m_adr;
    logic [15:0]   m_dat_w, m_dat_r;
    logic          m_ack;
    logic [15:0]   s_cyc, s_stb, s_we, s_ack;
    logic [7:0]    s_adr;
    logic [15:0]   s_dat_w;
    logic [255:0]  s_dat_r;

    always #(CLK_NS/2) clk = ~clk;

    wb_shared_bus #(
        .SLOT_MAP  (SLOT_MAP),
        .UNMAP_LAT (UNMAP_LAT)
    ) u0 (
        .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
        .m_adr(m_adr), .m_dat_w(m_dat_w), .m_dat_r(m_dat_r), .m_ack(m_ack),
        .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_dat_w(s_dat_w), .s_dat_r(s_dat_r), .s_ack(s_ack)
    );

    function automatic logic [15:0] init_val(int k, int a);
        return 16'(k * 16'h1111) ^ {8'(a), ~8'(a)};
    endfunction

    function automatic int exp_lat(int k);
        return SLOT_MAP[k] ? (k % 3) + 1 : UNMAP_LAT;
    endfunction

    // slave models: slot k inserts k%3 wait states
    logic [15:0] mem [16][256];
    logic [7:0]  wc [16];
    logic [15:0] model_ack;
    logic [15:0] stray;

    always_comb begin
        for (int k = 0; k < 16; k++) begin
            model_ack[k]          = s_stb[k] && (wc[k] == 8'(k % 3));
            s_dat_r[k*16 +: 16]   = mem[k][s_adr];
        end
        s_ack = model_ack | stray;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) begin
                wc[k] <= '0;
                for (int a = 0; a < 256; a++) mem[k][a] <= init_val(k, a);
            end
        end else begin
            for (int k = 0; k < 16; k++) begin
                if (s_stb[k] && !model_ack[k]) wc[k] <= wc[k] + 8'd1;
                else                           wc[k] <= '0;
                if (s_stb[k] && model_ack[k] && s_we[k]) mem[k][s_adr] <= s_dat_w;
            end
        end
    end

    logic [15:0] shadow [16][256];
    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic shadow_init();
        for (int k = 0; k < 16; k++)
            for (int a = 0; a < 256; a++) shadow[k][a] = init_val(k, a);
    endtask

    task automatic xfer(input int slot, input int rg, input bit we, input logic [15:0] wd,
                        input logic [15:0] smask, output logic [15:0] rd, output int ncyc);
        logic [15:0] exp_sel;
        bit done;
        exp_sel = SLOT_MAP[slot] ? (16'd1 << slot) : 16'd0;
        @(negedge clk);
        m_cyc = 1'b1; m_stb = 1'b1; m_we = we;
        m_adr = {4'(slot), 8'(rg)}; m_dat_w = wd; stray = smask;
        ncyc = 0; done = 1'b0; rd = '0;
        while (!done && ncyc < 20) begin
            #(CLK_NS/4);
            ncyc++;
            chk(s_stb == exp_sel && s_cyc == exp_sel, "R2 select", {s_cyc, s_stb}, {exp_sel, exp_sel});
            chk(s_we == (we ? exp_sel : 16'd0), "R4 we routing", 32'(s_we), 32'(we ? exp_sel : 16'd0));
            chk(s_adr == 8'(rg) && s_dat_w == wd, "R3 shared fwd", {8'd0, s_adr, s_dat_w}, {8'd0, 8'(rg), wd});
            if (m_ack) begin
                done = 1'b1;
                rd = m_dat_r;
            end else begin
                @(negedge clk);
            end
        end
        chk(done, "R5 R7 handshake completes", 32'(done), 32'd1);
        @(negedge clk);
        m_cyc = 1'b0; m_stb = 1'b0; m_we = 1'b0; stray = '0;
    endtask

    task automatic access(input int slot, input int rg, input bit we, input logic [15:0] wd,
                          input logic [15:0] smask);
        logic [15:0] rd;
        int ncyc;
        xfer(slot, rg, we, wd, smask, rd, ncyc);
        if (SLOT_MAP[slot]) begin
            chk(ncyc == exp_lat(slot), "R5 ack from target slot", 32'(ncyc), 32'(exp_lat(slot)));
            if (!we) chk(rd == shadow[slot][rg], "R6 read data", 32'(rd), 32'(shadow[slot][rg]));
            if (we) shadow[slot][rg] = wd;
        end else begin
            chk(ncyc == UNMAP_LAT, "R7 empty slot latency", 32'(ncyc), 32'(UNMAP_LAT));
            chk(rd == 16'h0000, "R7 empty slot data", 32'(rd), 32'd0);
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; m_cyc = 1'b0; m_stb = 1'b0; m_we = 1'b0;
        m_adr = '0; m_dat_w = '0; stray = '0;
        shadow_init();
        repeat (3) @(negedge clk);
        #(CLK_NS/4);
        chk(!m_ack && s_stb == '0 && s_cyc == '0, "R1 reset state", {15'd0, m_ack, s_stb}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // directed: bottom and top register of every slot
        for (int k = 0; k < 16; k++) begin
            access(k, 0, 1'b1, 16'hA500 ^ 16'(k), 16'h0);
            access(k, 0, 1'b0, 16'h0, 16'h0);
            access(k, 255, 1'b0, 16'h0, 16'h0);
        end

        // R8: cycle held without strobe, all slaves shouting ack
        @(negedge clk);
        m_cyc = 1'b1; m_stb = 1'b0; m_adr = 12'h210; stray = 16'hFFFF;
        repeat (3) begin
            #(CLK_NS/4);
            chk(!m_ack && s_stb == '0, "R8 no strobe no ack", {15'd0, m_ack, s_stb}, 32'd0);
            chk(s_cyc == 16'h0004, "R2 cycle to slot 2", 32'(s_cyc), 32'h4);
            @(negedge clk);
        end
        m_cyc = 1'b0; stray = '0;

        // R9: reset in the middle of an empty-slot access
        m_cyc = 1'b1; m_stb = 1'b1; m_we = 1'b0; m_adr = 12'hF10;
        begin
            int n;
            #(CLK_NS/4);
            chk(!m_ack, "R9 no early ack c1", 32'(m_ack), 32'd0);
            @(negedge clk); #(CLK_NS/4);
            chk(!m_ack, "R9 no early ack c2", 32'(m_ack), 32'd0);
            rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            shadow_init();
            n = 0;
            for (int i = 0; i < 10; i++) begin
                #(CLK_NS/4);
                n++;
                if (m_ack) break;
                @(negedge clk);
            end
            chk(n == UNMAP_LAT, "R9 count restarts after reset", 32'(n), 32'(UNMAP_LAT));
            @(negedge clk);
            m_cyc = 1'b0; m_stb = 1'b0;
        end

        // random traffic with stray acknowledges on other slots
        for (int i = 0; i < 400; i++) begin
            int slot;
            logic [15:0] sm;
            slot = int'($urandom % 16);
            sm = 16'($urandom);
            if (SLOT_MAP[slot]) sm = sm & ~(16'd1 << slot);
            access(slot, int'($urandom % 256), 1'($urandom), 16'($urandom), sm);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule